// File: doc/BRIEF.md
# Shadow Register Update Trigger Selector

This block sits beside one timer channel in a group of six timers and decides when that channel's preloaded compare and period values become live. Software writes new values into a bank of shadow registers through a simple write port. A set of enable inputs chooses which events may copy the whole shadow bank into the active bank in one step. The events are the channel's own counter reset or wrap, a wrap that happens while its repetition counter reads zero, and the update events of the five other timers.

All enabled and present events are merged into one transfer request. The transfer copies every shadow register into its active register on the same clock edge. A registered strobe reports the copy in the cycle in which the new active values appear. When preloading is switched off, writes bypass the shadow stage and land in the active register directly.

Top module: `shadow_update_sel`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every active register reads zero and xfer_o is low.
- R2: With rst_upd_en high, a cnt_reset pulse or a cnt_wrap pulse causes a transfer.
- R3: With rep_upd_en high, a cnt_wrap pulse causes a transfer only when rep_zero is high in the same cycle. cnt_reset alone never triggers through this path.
- R4: Bit i of xtmr_upd_en and xtmr_upd belongs to timer i, with A=0 through F=5. For every i other than SELF_IDX, a cycle with both bits high causes a transfer.
- R5: Bit SELF_IDX of xtmr_upd_en is reserved. A pulse on xtmr_upd[SELF_IDX] never causes a transfer, whatever that enable bit holds.
- R6: A source whose enable is low has no effect. With all enables low, no combination of event inputs causes a transfer.
- R7: xfer_o is high for exactly the one cycle after each cycle holding a transfer request. It is a single pulse even when several sources are active together.
- R8: A transfer copies every shadow register into its active register on the request edge. The new values are visible in the same cycle as xfer_o.
- R9: When a write to a register lands in the same cycle as a transfer, the written value becomes active.
- R10: With preload_en low, a write updates the addressed active register on the next edge without a transfer.
- R11: With preload_en high, a write does not change any active register until a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| preload_en | input | 1 | 1: writes go to the shadow stage; 0: writes go straight to the active registers |
| rst_upd_en | input | 1 | Enables transfer on the channel's counter reset or wrap |
| rep_upd_en | input | 1 | Enables transfer on a wrap while the repetition count is zero |
| xtmr_upd_en | input | NUM_TIMERS | Per-timer enables for the other timers' update events; bit SELF_IDX is reserved |
| cnt_reset | input | 1 | Pulse: the channel's counter was reset |
| cnt_wrap | input | 1 | Pulse: the channel's counter wrapped to zero after reaching its period |
| rep_zero | input | 1 | Level: the repetition counter reads zero |
| xtmr_upd | input | NUM_TIMERS | Update event pulses from the timers of the group |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | SEL_W | Register index for the write |
| wr_data | input | DATA_W | Write data |
| xfer_o | output | 1 | One-cycle strobe marking a completed transfer |
| act_flat_o | output | NUM_REGS*DATA_W | Active register values; register k occupies bits k*DATA_W upward |

## Verification
The table drives each trigger source alone, with its enable both set and cleared. This separates a source that works from one that fires regardless of its enable. Further rows cover mismatched enable and event bits, the reserved own-index bit alone and with every other enable set, and a wrap with the repetition count nonzero. These rows expose a selector that masks with the wrong bit or ignores the repetition condition. Rows with many sources active together show whether the strobe stays a single pulse. Directed cases then set a write against a transfer, bypass the shadow stage, hold a write without a trigger and reset mid-run. Each of these separates the ordering of shadow and active updates.

// File: rtl/shadow_update_pkg.sv
// Package: shared types for the shadow register update trigger selector.
// Assumes: nothing beyond IEEE 1800-2017.
package shadow_update_pkg;

    // Per-channel event inputs that come from the channel's own counter.
    typedef struct packed {
        logic cnt_reset;   // counter reset pulse
        logic cnt_wrap;    // counter wrap to zero pulse
        logic rep_zero;    // repetition counter currently zero
    } own_evt_t;

    // Enables for the channel's own event paths.
    typedef struct packed {
        logic rst_upd;     // transfer on reset or wrap
        logic rep_upd;     // transfer on wrap with repetition zero
    } own_en_t;

    // Builds a one-hot mask of the given width with bit idx set.
    function automatic logic [31:0] idx_mask(input int idx);
        logic [31:0] m;
        m = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/upd_trig_sel.sv
// Module: upd_trig_sel
// Merges the enabled transfer sources into one request and registers a
// one-cycle strobe for it. The cross-timer enable for this channel's own
// index is forced off.
// Assumes: event inputs are already synchronous to clk; SELF_IDX < NUM_TIMERS.
module upd_trig_sel
    import shadow_update_pkg::*;
#(
    parameter int NUM_TIMERS = 6,
    parameter int SELF_IDX   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  own_en_t               own_en,
    input  own_evt_t              own_evt,
    input  logic [NUM_TIMERS-1:0] xtmr_en,
    input  logic [NUM_TIMERS-1:0] xtmr_upd,
    output logic                  xfer_req,
    output logic                  xfer_q
);

    localparam logic [NUM_TIMERS-1:0] SELF_BIT = NUM_TIMERS'(idx_mask(SELF_IDX));
    localparam logic [NUM_TIMERS-1:0] XT_MASK  = ~SELF_BIT;

    logic [NUM_TIMERS-1:0] xt_hit;
    logic                  rst_path;
    logic                  rep_path;
    logic                  xt_path;

    // Per-timer cross triggers, one lane per timer, own lane tied off.
    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_lane
        if (g == SELF_IDX) begin : g_own
            assign xt_hit[g] = 1'b0;
        end else begin : g_other
            assign xt_hit[g] = xtmr_en[g] & xtmr_upd[g];
        end
    end

    // Combine the three source groups into one request.
    always_comb begin
        rst_path = own_en.rst_upd & (own_evt.cnt_reset | own_evt.cnt_wrap);
        rep_path = own_en.rep_upd & own_evt.cnt_wrap & own_evt.rep_zero;
        xt_path  = |xt_hit;
        xfer_req = rst_path | rep_path | xt_path;
    end

    // Register the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_q <= 1'b0;
        else        xfer_q <= xfer_req;
    end

    // R6: nothing enabled and present means no strobe next cycle.
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(own_en.rst_upd && (own_evt.cnt_reset || own_evt.cnt_wrap))
         && !(own_en.rep_upd && own_evt.cnt_wrap)
         && ((xtmr_en & xtmr_upd & XT_MASK) == '0)) |=> !xfer_q);

    // R5: the own-index lane alone never produces a strobe.
    p_own_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_en.rst_upd && !own_en.rep_upd && ((xtmr_upd & XT_MASK) == '0)) |=> !xfer_q);

    // R3: a wrap with nonzero repetition does not fire through the repetition path.
    p_rep_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_en.rst_upd && ((xtmr_en & xtmr_upd & XT_MASK) == '0)
         && own_evt.cnt_wrap && !own_evt.rep_zero) |=> !xfer_q);

    // R7: any request is followed by the strobe.
    p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> xfer_q);

endmodule

// File: rtl/shadow_cell.sv
// Module: shadow_cell
// One shadow/active register pair. A write lands in the shadow stage (or
// straight in the active stage when preload is off); a transfer copies the
// post-write shadow value into the active stage.
// Assumes: wr_hit and xfer are synchronous single-cycle qualifiers.
module shadow_cell #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_en,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              xfer,
    output logic [DATA_W-1:0] active_q
);

    logic [DATA_W-1:0] shadow_q;
    logic [DATA_W-1:0] shadow_d;

    // Next shadow value: a same-cycle write takes effect before the copy.
    always_comb begin
        shadow_d = wr_hit ? wr_data : shadow_q;
    end

    // Shadow stage storage.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= shadow_d;
    end

    // Active stage: direct write when bypassed, otherwise copy on transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                active_q <= '0;
        else if (!pre_en && wr_hit) active_q <= wr_data;
        else if (xfer)             active_q <= shadow_d;
    end

    // R11: with preload on, no write path reaches the active value alone.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !xfer) |=> $stable(active_q));

    // R10: bypass write appears on the next edge.
    p_direct_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_en && wr_hit) |=> (active_q == $past(wr_data)));

    // R8: a transfer without a write copies the held shadow value.
    p_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && xfer && !wr_hit) |=> (active_q == $past(shadow_q)));

    // R9: a write in the transfer cycle is what becomes active.
    p_new_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && xfer && wr_hit) |=> (active_q == $past(wr_data)));

endmodule

// File: rtl/shadow_bank.sv
// Module: shadow_bank
// A bank of NUM_REGS shadow/active pairs sharing one write port and one
// transfer request; outputs the active values flattened.
// Assumes: wr_sel addresses an existing register when wr_en is high;
// out-of-range indexes are dropped.
module shadow_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 16,
    parameter int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pre_en,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       xfer,
    output logic [NUM_REGS*DATA_W-1:0] act_flat
);

    logic [NUM_REGS-1:0] hit;

    // One register pair per index, each with its own write decode.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        assign hit[k] = wr_en && (int'(wr_sel) == k);

        shadow_cell #(.DATA_W(DATA_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .pre_en   (pre_en),
            .wr_hit   (hit[k]),
            .wr_data  (wr_data),
            .xfer     (xfer),
            .active_q (act_flat[k*DATA_W +: DATA_W])
        );
    end

    // At most one register is written per cycle.
    p_one_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/shadow_update_sel.sv
// Module: shadow_update_sel (top)
// Trigger selection plus shadow bank for one timer channel of a group.
// Assumes: all inputs synchronous to clk; reset is synchronous, active low.
module shadow_update_sel
    import shadow_update_pkg::*;
#(
    parameter int NUM_TIMERS = 6,
    parameter int SELF_IDX   = 2,
    parameter int NUM_REGS   = 4,
    parameter int DATA_W     = 16,
    parameter int SEL_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       preload_en,
    input  logic                       rst_upd_en,
    input  logic                       rep_upd_en,
    input  logic [NUM_TIMERS-1:0]      xtmr_upd_en,
    input  logic                       cnt_reset,
    input  logic                       cnt_wrap,
    input  logic                       rep_zero,
    input  logic [NUM_TIMERS-1:0]      xtmr_upd,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [DATA_W-1:0]          wr_data,
    output logic                       xfer_o,
    output logic [NUM_REGS*DATA_W-1:0] act_flat_o
);

    own_en_t  own_en;
    own_evt_t own_evt;
    logic     xfer_req;

    // Bundle the channel's own enables and events.
    always_comb begin
        own_en.rst_upd    = rst_upd_en;
        own_en.rep_upd    = rep_upd_en;
        own_evt.cnt_reset = cnt_reset;
        own_evt.cnt_wrap  = cnt_wrap;
        own_evt.rep_zero  = rep_zero;
    end

    upd_trig_sel #(
        .NUM_TIMERS (NUM_TIMERS),
        .SELF_IDX   (SELF_IDX)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .own_en   (own_en),
        .own_evt  (own_evt),
        .xtmr_en  (xtmr_upd_en),
        .xtmr_upd (xtmr_upd),
        .xfer_req (xfer_req),
        .xfer_q   (xfer_o)
    );

    shadow_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .SEL_W    (SEL_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_en   (preload_en),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .xfer     (xfer_req),
        .act_flat (act_flat_o)
    );

    // R2: an enabled reset/wrap event is followed by the strobe.
    p_rst_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_upd_en && (cnt_reset || cnt_wrap)) |=> xfer_o);

    // R4: an enabled update from another timer is followed by the strobe.
    p_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((xtmr_upd_en & xtmr_upd & ~NUM_TIMERS'(idx_mask(SELF_IDX))) != '0) |=> xfer_o);

endmodule

// File: tb/test_shadow_update_sel.sv
// Testbench for shadow_update_sel: a vector table of trigger patterns,
// then directed tests for reset, ordering and bypass.
module test_shadow_update_sel;

    localparam int NT = 6;
    localparam int NR = 4;
    localparam int DW = 16;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          preload_en, rst_upd_en, rep_upd_en;
    logic [NT-1:0] xtmr_upd_en, xtmr_upd;
    logic          cnt_reset, cnt_wrap, rep_zero;
    logic          wr_en;
    logic [SW-1:0] wr_sel;
    logic [DW-1:0] wr_data;
    logic          xfer_o;
    logic [NR*DW-1:0] act_flat_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    shadow_update_sel i_shadow_update_sel (
        .clk(clk), .rst_n(rst_n), .preload_en(preload_en),
        .rst_upd_en(rst_upd_en), .rep_upd_en(rep_upd_en), .xtmr_upd_en(xtmr_upd_en),
        .cnt_reset(cnt_reset), .cnt_wrap(cnt_wrap), .rep_zero(rep_zero),
        .xtmr_upd(xtmr_upd), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .xfer_o(xfer_o), .act_flat_o(act_flat_o)
    );

    // Vector: {rst_en, rep_en, xen[5:0], creset, cwrap, repz, xupd[5:0], exp}
    // SELF_IDX defaults to 2 (timer C).
    localparam logic [17:0] VEC [14] = '{
        18'b0_0_000000_1_1_1_111111_0, // R6 all enables off
        18'b1_0_000000_1_0_0_000000_1, // R2 reset
        18'b1_0_000000_0_1_0_000000_1, // R2 wrap
        18'b0_1_000000_0_1_1_000000_1, // R3 wrap, rep zero
        18'b0_1_000000_0_1_0_000000_0, // R3 wrap, rep nonzero
        18'b0_1_000000_1_0_1_000000_0, // R3 reset alone
        18'b0_0_000001_0_0_0_000001_1, // R4 timer A
        18'b0_0_100000_0_0_0_100000_1, // R4 timer F
        18'b0_0_000100_0_0_0_000100_0, // R5 own bit
        18'b0_0_111011_0_0_0_000100_0, // R5 own pulse, others enabled
        18'b0_0_000010_0_0_0_000001_0, // R6 mismatched lane
        18'b1_1_111111_1_1_1_111111_1, // R7 everything
        18'b1_0_000000_0_0_0_111111_0, // R6 cross events, cross enables off
        18'b0_0_111111_0_0_0_111111_1  // R4 all lanes
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        rst_upd_en = 0; rep_upd_en = 0; xtmr_upd_en = '0;
        cnt_reset = 0; cnt_wrap = 0; rep_zero = 0; xtmr_upd = '0;
        wr_en = 0; wr_sel = '0; wr_data = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] act_of(input int k);
        return act_flat_o[k*DW +: DW];
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] model0;
        rst_n = 0; preload_en = 1; idle();
        @(negedge clk);
        step();
        rst_n = 1;
        // R1 reset state
        check("R1 xfer", {15'b0, xfer_o}, 16'h0);
        for (int k = 0; k < NR; k++) check("R1 active", act_of(k), 16'h0);

        model0 = '0;
        for (int i = 0; i < 14; i++) begin
            logic [17:0] v;
            v = VEC[i];
            // load a fresh shadow value into register 0
            idle(); wr_en = 1; wr_sel = 0; wr_data = 16'h1000 + 16'(i);
            step();
            idle();
            rst_upd_en = v[17]; rep_upd_en = v[16]; xtmr_upd_en = v[15:10];
            cnt_reset = v[9]; cnt_wrap = v[8]; rep_zero = v[7]; xtmr_upd = v[6:1];
            step();
            if (v[0]) model0 = 16'h1000 + 16'(i);
            check($sformatf("R2/R3/R4/R5/R6 xfer vec %0d", i), {15'b0, xfer_o}, {15'b0, v[0]});
            check($sformatf("R8 active vec %0d", i), act_of(0), model0);
            idle();
            step();
            check($sformatf("R7 single pulse vec %0d", i), {15'b0, xfer_o}, 16'h0);
        end

        // R8: all registers move together on one transfer
        for (int k = 0; k < NR; k++) begin
            idle(); wr_en = 1; wr_sel = SW'(k); wr_data = 16'hA000 + 16'(k);
            step();
        end
        idle(); rst_upd_en = 1; cnt_wrap = 1;
        step();
        for (int k = 0; k < NR; k++) check("R8 all registers", act_of(k), 16'hA000 + 16'(k));

        // R9: write in the transfer cycle wins
        idle(); rst_upd_en = 1; cnt_reset = 1; wr_en = 1; wr_sel = 1; wr_data = 16'h5A5A;
        step();
        check("R9 same-cycle write", act_of(1), 16'h5A5A);

        // R11: preload on, write without trigger leaves active alone
        idle(); wr_en = 1; wr_sel = 3; wr_data = 16'hBEEF;
        step(); idle(); step();
        check("R11 held", act_of(3), 16'hA003);

        // R10: bypass writes go straight to active
        preload_en = 0;
        idle(); wr_en = 1; wr_sel = 2; wr_data = 16'hC0DE;
        step();
        check("R10 direct", act_of(2), 16'hC0DE);
        check("R10 no strobe", {15'b0, xfer_o}, 16'h0);
        preload_en = 1;

        // R1: reset mid-run clears everything
        idle(); rst_n = 0;
        step();
        for (int k = 0; k < NR; k++) check("R1 mid-run reset", act_of(k), 16'h0);
        rst_n = 1;
        step();

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule